// File: doc/BRIEF.md
# GPIO Bank Interrupt Event Detector

This block watches the synchronized levels of a bank of general-purpose lines and turns chosen transitions or levels into latched interrupt events. Each line carries its own 3-bit event-select code, supplied from the pin configuration. The code picks one of five detection modes: falling edge, rising edge, either edge, low level or high level.

A detected event sets that line's bit in a status register. Software reads the status register to collect the events, and that read also clears them, so no acknowledge write is needed. Two write-one registers, one to enable and one to disable, build a read-only mask. The bank's single interrupt output is high whenever any status bit is set and its mask bit is also set.

The block sits behind a simple single-cycle register port. It has one write strobe, one read strobe, an offset and write data, and the read data is returned combinationally in the same cycle as the read strobe.

Top module: `gpio_evt_irq`

## Requirements
- R1: With select code 0 (falling), 1 (rising) or 2 (either edge), a line sets its status bit at the clock edge where its sampled level differs from the level sampled at the previous edge in the chosen direction.
- R2: With select code 3 (low) or 4 (high), a line sets its status bit at every clock edge where its level matches the code. This includes the edge right after a clearing read.
- R3: Select codes 5, 6 and 7 never set a status bit, whatever the line does.
- R4: The first level sampled after reset is taken as the reference, so no edge is detected at that edge even when the line is already high.
- R5: A write at offset 0x20 sets every mask bit whose write-data bit is 1 and leaves the other mask bits unchanged.
- R6: A write at offset 0x24 clears every mask bit whose write-data bit is 1 and leaves the other mask bits unchanged.
- R7: A read at offset 0x28 returns the mask, which is all zeros after reset. A read at any unmapped offset returns zero.
- R8: A read at offset 0x2C returns the status, which is zero after reset, and clears it at the next clock edge. An event detected at that same edge stays latched.
- R9: Status bits latch whatever the mask holds. The interrupt output is 1 exactly when some bit is set in both status and mask, and it is 0 after reset.
- R10: A status bit stays set until a status read clears it, even after the line returns to its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_lvl | input | NLINE | Synchronized line levels |
| evt_sel | input | 3*NLINE | Event-select code per line, line i in bits 3i+2..3i |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | NLINE | Write data |
| bus_rdata | output | NLINE | Read data, valid in the cycle of the read strobe |
| irq | output | 1 | Bank interrupt |

## Verification
The hardest cases to reach from the ports are collisions in time. One is a new event arriving at the very edge where a status read clears the register. Another is a level-mode line re-setting its bit right after the clear. A third is a line that is already high as reset is released.

Directed sequences set up each of these. They change the line level in the same cycle as the read strobe, and they release a second reset with every line high in rising mode. Long random runs of line toggles, code changes and register accesses then check the read data and the interrupt every cycle against a bench model.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

    typedef enum logic [2:0] {
        EV_FALL = 3'd0,
        EV_RISE = 3'd1,
        EV_BOTH = 3'd2,
        EV_LOW  = 3'd3,
        EV_HIGH = 3'd4
    } ev_mode_e;

    localparam int OFS_EN   = 32'h20;
    localparam int OFS_DIS  = 32'h24;
    localparam int OFS_MASK = 32'h28;
    localparam int OFS_STAT = 32'h2C;

    // Decide whether one line raises an event this cycle.
    function automatic logic ev_hit(input logic [2:0] code, input logic now,
                                    input logic last, input logic armed);
        logic hit;
        case (code)
            EV_FALL: hit = armed & last & ~now;
            EV_RISE: hit = armed & ~last & now;
            EV_BOTH: hit = armed & (last ^ now);
            EV_LOW:  hit = ~now;
            EV_HIGH: hit = now;
            default: hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
    import gpio_evt_pkg::*;
#(
    parameter int NLINE = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NLINE-1:0]   lvl,
    input  logic [3*NLINE-1:0] sel,
    output logic [NLINE-1:0]   evt
);

    typedef struct packed {
        logic [NLINE-1:0] prev;
        logic             primed;
    } det_t;

    det_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.prev   = lvl;
        st_d.primed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < NLINE; i++) begin : g_line
        assign evt[i] = ev_hit(sel[3*i +: 3], lvl[i], st_q.prev[i], st_q.primed);
    end

endmodule

// File: rtl/gpio_evt_regs.sv
module gpio_evt_regs
    import gpio_evt_pkg::*;
#(
    parameter int NLINE  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NLINE-1:0]  wdata,
    input  logic [NLINE-1:0]  evt,
    output logic [NLINE-1:0]  rdata,
    output logic [NLINE-1:0]  mask,
    output logic [NLINE-1:0]  status
);

    typedef struct packed {
        logic [NLINE-1:0] mask;
        logic [NLINE-1:0] status;
    } reg_t;

    reg_t r_d, r_q;

    logic hit_en, hit_dis, hit_mask, hit_stat;

    always_comb begin
        hit_en   = (addr == ADDR_W'(OFS_EN));
        hit_dis  = (addr == ADDR_W'(OFS_DIS));
        hit_mask = (addr == ADDR_W'(OFS_MASK));
        hit_stat = (addr == ADDR_W'(OFS_STAT));

        r_d = r_q;
        if (wr && hit_en)  r_d.mask = r_q.mask | wdata;
        if (wr && hit_dis) r_d.mask = r_q.mask & ~wdata;
        // A new event wins over the clearing read at the same edge.
        r_d.status = ((rd && hit_stat) ? '0 : r_q.status) | evt;

        if (hit_mask)      rdata = r_q.mask;
        else if (hit_stat) rdata = r_q.status;
        else               rdata = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mask   = r_q.mask;
    assign status = r_q.status;

endmodule

// File: rtl/gpio_evt_irq.sv
module gpio_evt_irq
    import gpio_evt_pkg::*;
#(
    parameter int NLINE  = 32,
    parameter int ADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NLINE-1:0]   line_lvl,
    input  logic [3*NLINE-1:0] evt_sel,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [NLINE-1:0]   bus_wdata,
    output logic [NLINE-1:0]   bus_rdata,
    output logic               irq
);

    logic [NLINE-1:0] evt_w;
    logic [NLINE-1:0] mask_w;
    logic [NLINE-1:0] status_w;

    gpio_evt_detect #(.NLINE(NLINE)) u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (line_lvl),
        .sel   (evt_sel),
        .evt   (evt_w)
    );

    gpio_evt_regs #(.NLINE(NLINE), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (bus_wr),
        .rd     (bus_rd),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .evt    (evt_w),
        .rdata  (bus_rdata),
        .mask   (mask_w),
        .status (status_w)
    );

    assign irq = |(status_w & mask_w);

endmodule

// File: rtl/gpio_evt_chk.sv
module gpio_evt_chk
    import gpio_evt_pkg::*;
#(
    parameter int NLINE  = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NLINE-1:0]  bus_wdata,
    input logic [NLINE-1:0]  mask_w,
    input logic [NLINE-1:0]  status_w,
    input logic [NLINE-1:0]  evt_w,
    input logic              irq
);

    logic en_wr, dis_wr, stat_rd;
    assign en_wr   = bus_wr && (bus_addr == ADDR_W'(OFS_EN));
    assign dis_wr  = bus_wr && (bus_addr == ADDR_W'(OFS_DIS));
    assign stat_rd = bus_rd && (bus_addr == ADDR_W'(OFS_STAT));

    p_enable_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> ((mask_w & $past(bus_wdata)) == $past(bus_wdata)));

    p_disable_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dis_wr |=> ((mask_w & $past(bus_wdata)) == '0));

    p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_wr || dis_wr) |=> $stable(mask_w));

    p_clear_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && evt_w == '0) |=> (status_w == '0));

    p_status_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> ((status_w & $past(status_w)) == $past(status_w)));

    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_w == '0) |-> !irq);

    p_event_latched_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_w & ~mask_w) != '0) |=> ((status_w & ~$past(mask_w)) != '0));

endmodule

bind gpio_evt_irq gpio_evt_chk #(.NLINE(NLINE), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .mask_w    (mask_w),
    .status_w  (status_w),
    .evt_w     (evt_w),
    .irq       (irq)
);

// File: tb/sim_gpio_evt_irq.sv
`timescale 1ns/1ps
module sim_gpio_evt_irq;
    localparam int NL = 32;
    localparam int AW = 8;
    localparam logic [AW-1:0] A_EN = 8'h20, A_DIS = 8'h24, A_MASK = 8'h28, A_STAT = 8'h2C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NL-1:0]   line_lvl = '0;
    logic [3*NL-1:0] evt_sel = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [NL-1:0] bus_wdata = '0;
    logic [NL-1:0] bus_rdata;
    logic irq;

    always #2.5 clk = ~clk;

    gpio_evt_irq #(.NLINE(NL), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .line_lvl(line_lvl), .evt_sel(evt_sel),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    logic [NL-1:0] m_prev, m_status, m_mask;
    logic m_primed;
    logic [NL-1:0]   lvl_r = '0;
    logic [3*NL-1:0] sel_r = '0;

    function automatic logic hit(logic [2:0] s, logic l, logic p, logic pr);
        case (s)
            3'd0: return pr && p && !l;
            3'd1: return pr && !p && l;
            3'd2: return pr && (p != l);
            3'd3: return !l;
            3'd4: return l;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [NL-1:0] exp_read(logic [AW-1:0] a);
        if (a == A_MASK) return m_mask;
        if (a == A_STAT) return m_status;
        return '0;
    endfunction

    task automatic check(string tag, logic [NL-1:0] act, logic [NL-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One bus cycle: drive at the falling edge, check, then advance the model.
    task automatic cyc(logic wr, logic rd, logic [AW-1:0] a, logic [NL-1:0] wd, string tag);
        logic [NL-1:0] ev;
        @(negedge clk);
        line_lvl = lvl_r; evt_sel = sel_r;
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
        #1;
        check("R9 irq", {{(NL-1){1'b0}}, irq}, {{(NL-1){1'b0}}, |(m_status & m_mask)});
        if (rd) check(tag, bus_rdata, exp_read(a));
        for (int i = 0; i < NL; i++) ev[i] = hit(sel_r[3*i +: 3], lvl_r[i], m_prev[i], m_primed);
        if (wr && a == A_EN)  m_mask = m_mask | wd;
        if (wr && a == A_DIS) m_mask = m_mask & ~wd;
        m_status = ((rd && a == A_STAT) ? '0 : m_status) | ev;
        m_prev = lvl_r;
        m_primed = 1'b1;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) cyc(1'b0, 1'b0, 8'h00, '0, "idle");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        line_lvl = lvl_r; evt_sel = sel_r;
        bus_wr = 1'b0; bus_rd = 1'b0;
        m_prev = '0; m_status = '0; m_mask = '0; m_primed = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd1357);
        // Reset state
        lvl_r = '0; sel_r = '0;
        do_reset();
        cyc(1'b0, 1'b1, A_MASK, '0, "R7 reset mask");
        cyc(1'b0, 1'b1, A_STAT, '0, "R8 reset status");
        cyc(1'b0, 1'b1, 8'h10, '0, "R7 unmapped read");
        // Mask building
        cyc(1'b1, 1'b0, A_EN, 32'h0000_00FF, "R5");
        cyc(1'b0, 1'b1, A_MASK, '0, "R5 enable sets");
        cyc(1'b1, 1'b0, A_DIS, 32'h0000_000F, "R6");
        cyc(1'b0, 1'b1, A_MASK, '0, "R6 disable clears");
        cyc(1'b1, 1'b0, A_EN, 32'hFFFF_FFFF, "R5");
        // Rising edges
        sel_r = {NL{3'd1}};
        lvl_r = 32'h0000_0005; idle(2);
        cyc(1'b0, 1'b1, A_STAT, '0, "R1 rising");
        // Falling edges
        sel_r = {NL{3'd0}};
        lvl_r = 32'h0000_0001; idle(2);
        cyc(1'b0, 1'b1, A_STAT, '0, "R1 falling");
        // Either edge
        sel_r = {NL{3'd2}};
        lvl_r = 32'h0000_0102; idle(2);
        cyc(1'b0, 1'b1, A_STAT, '0, "R1 both");
        // Codes that detect nothing
        for (int i = 0; i < NL; i++) sel_r[3*i +: 3] = 3'(5 + (i % 3));
        lvl_r = 32'hA5A5_5A5A; idle(1);
        lvl_r = 32'h0000_0000; idle(1);
        cyc(1'b0, 1'b1, A_STAT, '0, "R3 codes 5-7");
        // Level modes, re-set right after a clearing read
        sel_r = {NL{3'd7}};
        sel_r[3*3 +: 3] = 3'd4;
        sel_r[3*6 +: 3] = 3'd3;
        lvl_r = 32'h0000_0008; idle(1);
        cyc(1'b0, 1'b1, A_STAT, '0, "R2 level");
        cyc(1'b0, 1'b1, A_STAT, '0, "R2 level after clear");
        // Event at the same edge as a clearing read
        sel_r = {NL{3'd1}};
        lvl_r = 32'h0000_0000; idle(1);
        cyc(1'b0, 1'b1, A_STAT, '0, "R8 flush");
        lvl_r = 32'h0001_0000;
        cyc(1'b0, 1'b1, A_STAT, '0, "R8 read with event");
        cyc(1'b0, 1'b1, A_STAT, '0, "R8 event survives");
        // Stickiness
        lvl_r = 32'h0000_0000; idle(1);
        lvl_r = 32'h0000_0400; idle(1);
        lvl_r = 32'h0000_0000; idle(4);
        cyc(1'b0, 1'b1, A_STAT, '0, "R10 sticky");
        // Latching while masked
        cyc(1'b1, 1'b0, A_DIS, 32'hFFFF_FFFF, "R6");
        lvl_r = 32'h0000_0020; idle(2);
        cyc(1'b0, 1'b1, A_STAT, '0, "R9 latch while masked");
        // First sample after reset
        lvl_r = '1; sel_r = {NL{3'd1}};
        do_reset();
        idle(3);
        cyc(1'b0, 1'b1, A_STAT, '0, "R4 no edge at reset");
        // Random traffic
        for (int n = 0; n < 3000; n++) begin
            int op;
            lvl_r = lvl_r ^ ($urandom() & $urandom() & $urandom());
            if ($urandom_range(0, 15) == 0)
                for (int i = 0; i < NL; i++) sel_r[3*i +: 3] = 3'($urandom_range(0, 7));
            op = $urandom_range(0, 9);
            case (op)
                0: cyc(1'b1, 1'b0, A_EN, $urandom(), "R5");
                1: cyc(1'b1, 1'b0, A_DIS, $urandom(), "R6");
                2: cyc(1'b0, 1'b1, A_MASK, '0, "R7 random mask");
                3, 4: cyc(1'b0, 1'b1, A_STAT, '0, "R8 random status");
                5: cyc(1'b0, 1'b1, 8'h04, '0, "R7 random unmapped");
                default: cyc(1'b0, 1'b0, 8'h00, '0, "idle");
            endcase
        end
        cyc(1'b0, 1'b1, A_STAT, '0, "R10 final status");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule